// File: doc/BRIEF.md
# Multi-Round Challenge-Response Verifier Controller

This block is the verifier side of an interactive proof that runs for a set number of rounds. In each round the prover hands over a freshly permuted copy of its marked data. The controller then draws a one-bit coin and sends it out as the challenge. A coin of 0 asks the prover to reveal the permutation seed. A coin of 1 asks it to reveal the mark positions inside the permuted copy. Only the requested reveal is accepted. The controller then asks an external checking engine to judge that reveal, using the same coin value to say which kind of check to run.

A prover that cheats can pass a single round with probability one half. For that reason the controller declares acceptance only after `ROUNDS` consecutive passes, and every round needs a new commit and a new coin. A single failed check, or a reveal of the wrong kind, sends the controller into a rejection state. That state holds until reset.

The coin is taken from a free-running 16-bit Galois LFSR. It uses feedback mask 0xB400 and shifts right every clock. Its seed is forced to be nonzero at reset, and the coin is bit 0 of the LFSR, sampled when the commit is taken.

States and transitions: IDLE goes to WAIT_COMMIT on `start`. WAIT_COMMIT goes to CHALLENGE on a commit. CHALLENGE lasts one cycle and goes to WAIT_RESPONSE. WAIT_RESPONSE goes to CHECK on a reveal of the right kind, or to REJECT on a reveal of the wrong kind. CHECK goes to NEXT on a passing result, or to REJECT on a failing one. NEXT goes to ACCEPT on the last round, otherwise back to WAIT_COMMIT. ACCEPT goes to WAIT_COMMIT on `start`. REJECT holds until reset.

Top module: `verify_round_ctrl`

## Requirements
- R1: After reset, `commit_ready`, `chal_valid`, `resp_ready`, `check_req`, `accept` and `reject` are all 0, and `rounds_passed` is 0.
- R2: `start`, seen in IDLE or ACCEPT, begins a session. One cycle later `commit_ready` is 1, `rounds_passed` is 0 and `accept` is 0.
- R3: A commit is taken only in a cycle where both `commit_valid` and `commit_ready` are 1. In the following cycle `chal_valid` is 1, and it lasts exactly one cycle. `chal_bit` (0 means reveal the seed, 1 means reveal the positions) stays constant from the challenge until the check finishes.
- R4: The coin comes from a nonzero free-running LFSR. Across many rounds, both coin values occur.
- R5: A reveal is taken only while `resp_ready` is 1. If `resp_kind` differs from `chal_bit`, `reject` is 1 in the following cycle.
- R6: After a reveal of the right kind, `check_req` is 1, with `check_kind` equal to `chal_bit`, until `check_done`. A `check_done` with `check_pass`=0 makes `reject` go to 1.
- R7: `rounds_passed` goes up by exactly one for each passed round. `accept` is 1 only once `rounds_passed` equals `ROUNDS`, and it is never 1 earlier in the session.
- R8: `reject` is sticky: it stays 1, and `start` and commits have no effect, until reset.
- R9: `commit_valid`, `resp_valid` and `check_done` are ignored outside WAIT_COMMIT, WAIT_RESPONSE and CHECK respectively.
- R10: Each round needs a new commit. A `commit_valid` held high through the NEXT state is taken only once WAIT_COMMIT is reached, so it counts for exactly one round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a verification session |
| commit_valid | input | 1 | Prover offers a new permuted copy |
| commit_ready | output | 1 | Controller is waiting for a commit |
| chal_valid | output | 1 | One-cycle challenge strobe |
| chal_bit | output | 1 | Coin: 0 reveal seed, 1 reveal positions |
| resp_valid | input | 1 | Prover presents its reveal |
| resp_kind | input | 1 | Which reveal the prover sent |
| resp_ready | output | 1 | Controller is waiting for a reveal |
| check_req | output | 1 | Request to the external checking engine |
| check_kind | output | 1 | Which check to run (equals the coin) |
| check_done | input | 1 | Checking engine has finished |
| check_pass | input | 1 | Verdict from the checking engine |
| rounds_passed | output | $clog2(ROUNDS+1) | Rounds passed so far in this session |
| accept | output | 1 | Proof accepted |
| reject | output | 1 | Proof rejected (sticky) |

## Verification
Two of the block's functions can land in the same cycle. First, a pass on the final round coincides with the counter reaching its terminal count. The bench judges this by requiring `accept` exactly when `rounds_passed` first equals `ROUNDS`, and checking that `accept` is low after every earlier pass. Second, a new commit can arrive in the same cycle as the previous round's check result. The bench provokes this by raising `commit_valid` together with `check_done` and holding it high. It then checks that the commit is not taken in NEXT and is counted once, for the next round only. Both sequences run inside seeded random sessions with random delays and injected failures.

// File: rtl/vr_pkg.sv
package vr_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_COMMIT,
        S_CHALLENGE,
        S_WAIT_RESPONSE,
        S_CHECK,
        S_NEXT,
        S_ACCEPT,
        S_REJECT
    } vr_state_t;

    localparam logic COIN_SEED_REVEAL = 1'b0;
    localparam logic COIN_POS_REVEAL  = 1'b1;
endpackage

// File: rtl/vr_coin_lfsr.sv
module vr_coin_lfsr #(
    parameter int          W     = 16,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic         coin,
    output logic [W-1:0] state_q
);
    localparam logic [W-1:0] SAFE_SEED = (SEED == '0) ? W'(1) : SEED;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SAFE_SEED;
        end else if (state_q[0]) begin
            state_q <= (state_q >> 1) ^ TAPS;
        end else begin
            state_q <= state_q >> 1;
        end
    end

    assign coin = state_q[0];
endmodule

// File: rtl/vr_round_counter.sv
module vr_round_counter #(
    parameter int ROUNDS = 8,
    parameter int CW     = $clog2(ROUNDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count,
    output logic          last
);
    localparam logic [CW-1:0] LAST_VAL = CW'(ROUNDS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    assign last = (count == LAST_VAL);
endmodule

// File: rtl/vr_fsm.sv
module vr_fsm
    import vr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      commit_valid,
    input  logic      resp_valid,
    input  logic      resp_kind,
    input  logic      check_done,
    input  logic      check_pass,
    input  logic      coin_in,
    input  logic      last_round,
    output vr_state_t state,
    output logic      coin_q,
    output logic      cnt_clr,
    output logic      cnt_inc,
    output logic      commit_ready,
    output logic      chal_valid,
    output logic      resp_ready,
    output logic      check_req,
    output logic      accept,
    output logic      reject
);
    vr_state_t nxt;
    logic      take_commit;

    assign take_commit = (state == S_WAIT_COMMIT) && commit_valid;

    // state register and the coin latched at commit time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            coin_q <= 1'b0;
        end else begin
            state <= nxt;
            if (take_commit) begin
                coin_q <= coin_in;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:          if (start) nxt = S_WAIT_COMMIT;
            S_WAIT_COMMIT:   if (commit_valid) nxt = S_CHALLENGE;
            S_CHALLENGE:     nxt = S_WAIT_RESPONSE;
            S_WAIT_RESPONSE: begin
                if (resp_valid) begin
                    nxt = (resp_kind == coin_q) ? S_CHECK : S_REJECT;
                end
            end
            S_CHECK: begin
                if (check_done) begin
                    nxt = check_pass ? S_NEXT : S_REJECT;
                end
            end
            S_NEXT:          nxt = last_round ? S_ACCEPT : S_WAIT_COMMIT;
            S_ACCEPT:        if (start) nxt = S_WAIT_COMMIT;
            S_REJECT:        nxt = S_REJECT;
            default:         nxt = S_IDLE;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        commit_ready = 1'b0;
        chal_valid   = 1'b0;
        resp_ready   = 1'b0;
        check_req    = 1'b0;
        accept       = 1'b0;
        reject       = 1'b0;
        cnt_inc      = 1'b0;
        cnt_clr      = 1'b0;
        unique case (state)
            S_IDLE:          cnt_clr = start;
            S_WAIT_COMMIT:   commit_ready = 1'b1;
            S_CHALLENGE:     chal_valid = 1'b1;
            S_WAIT_RESPONSE: resp_ready = 1'b1;
            S_CHECK:         check_req = 1'b1;
            S_NEXT:          cnt_inc = 1'b1;
            S_ACCEPT: begin
                accept  = 1'b1;
                cnt_clr = start;
            end
            S_REJECT:        reject = 1'b1;
            default:         ;
        endcase
    end
endmodule

// File: rtl/verify_round_ctrl.sv
module verify_round_ctrl
    import vr_pkg::*;
#(
    parameter int          ROUNDS    = 8,
    parameter int          LFSR_W    = 16,
    parameter logic [15:0] LFSR_SEED = 16'hACE1,
    parameter logic [15:0] LFSR_TAPS = 16'hB400
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          commit_valid,
    output logic                          commit_ready,
    output logic                          chal_valid,
    output logic                          chal_bit,
    input  logic                          resp_valid,
    input  logic                          resp_kind,
    output logic                          resp_ready,
    output logic                          check_req,
    output logic                          check_kind,
    input  logic                          check_done,
    input  logic                          check_pass,
    output logic [$clog2(ROUNDS+1)-1:0]   rounds_passed,
    output logic                          accept,
    output logic                          reject
);
    localparam int CW = $clog2(ROUNDS + 1);

    logic              coin;
    logic [LFSR_W-1:0] lfsr_state;
    logic              coin_q;
    logic              cnt_clr;
    logic              cnt_inc;
    logic              last_round;
    vr_state_t         state;

    vr_coin_lfsr #(
        .W    (LFSR_W),
        .SEED (LFSR_W'(LFSR_SEED)),
        .TAPS (LFSR_W'(LFSR_TAPS))
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .coin    (coin),
        .state_q (lfsr_state)
    );

    vr_round_counter #(
        .ROUNDS (ROUNDS),
        .CW     (CW)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (rounds_passed),
        .last  (last_round)
    );

    vr_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .commit_valid (commit_valid),
        .resp_valid   (resp_valid),
        .resp_kind    (resp_kind),
        .check_done   (check_done),
        .check_pass   (check_pass),
        .coin_in      (coin),
        .last_round   (last_round),
        .state        (state),
        .coin_q       (coin_q),
        .cnt_clr      (cnt_clr),
        .cnt_inc      (cnt_inc),
        .commit_ready (commit_ready),
        .chal_valid   (chal_valid),
        .resp_ready   (resp_ready),
        .check_req    (check_req),
        .accept       (accept),
        .reject       (reject)
    );

    assign chal_bit   = coin_q;
    assign check_kind = coin_q;
endmodule

// File: rtl/vr_checker.sv
module vr_checker #(
    parameter int ROUNDS = 8,
    parameter int CW     = 4,
    parameter int LW     = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          commit_valid,
    input logic          commit_ready,
    input logic          chal_valid,
    input logic          chal_bit,
    input logic          resp_valid,
    input logic          resp_kind,
    input logic          resp_ready,
    input logic          check_req,
    input logic          check_kind,
    input logic          check_done,
    input logic [CW-1:0] rounds_passed,
    input logic          accept,
    input logic          reject,
    input logic [LW-1:0] lfsr_state
);
    // R1
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_ready, chal_valid, resp_ready, check_req, accept, reject}));

    // R3
    commit_to_chal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && commit_ready) |=> chal_valid);

    // R3
    chal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chal_valid |=> !chal_valid);

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0);

    // R5
    wrong_reveal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_ready && (resp_kind != chal_bit)) |=> reject);

    // R6
    check_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (check_req && !check_done) |=> (check_req && $stable(check_kind)));

    // R7
    accept_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (rounds_passed == CW'(ROUNDS)));

    // R8
    reject_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> reject);
endmodule

bind verify_round_ctrl vr_checker #(
    .ROUNDS (ROUNDS),
    .CW     (CW),
    .LW     (LFSR_W)
) u_vr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit_valid  (commit_valid),
    .commit_ready  (commit_ready),
    .chal_valid    (chal_valid),
    .chal_bit      (chal_bit),
    .resp_valid    (resp_valid),
    .resp_kind     (resp_kind),
    .resp_ready    (resp_ready),
    .check_req     (check_req),
    .check_kind    (check_kind),
    .check_done    (check_done),
    .rounds_passed (rounds_passed),
    .accept        (accept),
    .reject        (reject),
    .lfsr_state    (lfsr_state)
);

// File: tb/test_verify_round_ctrl.sv
module test_verify_round_ctrl;
    localparam int ROUNDS = 8;
    localparam int CW     = $clog2(ROUNDS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          commit_valid = 1'b0;
    logic          resp_valid = 1'b0;
    logic          resp_kind = 1'b0;
    logic          check_done = 1'b0;
    logic          check_pass = 1'b0;
    logic          commit_ready, chal_valid, chal_bit, resp_ready;
    logic          check_req, check_kind, accept, reject;
    logic [CW-1:0] rounds_passed;

    int n_tests = 0;
    int n_fail  = 0;
    int seen0   = 0;
    int seen1   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    verify_round_ctrl #(.ROUNDS(ROUNDS)) i_verify_round_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .commit_valid  (commit_valid),
        .commit_ready  (commit_ready),
        .chal_valid    (chal_valid),
        .chal_bit      (chal_bit),
        .resp_valid    (resp_valid),
        .resp_kind     (resp_kind),
        .resp_ready    (resp_ready),
        .check_req     (check_req),
        .check_kind    (check_kind),
        .check_done    (check_done),
        .check_pass    (check_pass),
        .rounds_passed (rounds_passed),
        .accept        (accept),
        .reject        (reject)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // expected acceptance flag after k passes in a session
    function automatic bit exp_accept(input int k);
        return (k == ROUNDS);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        start = 0; commit_valid = 0; resp_valid = 0; check_done = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic begin_session();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(commit_ready == 1'b1, "R2 commit_ready", commit_ready, 1);
        chk(rounds_passed == 0, "R2 rounds_passed", rounds_passed, 0);
        chk(accept == 1'b0, "R2 accept", accept, 0);
    endtask

    // one round; outcome: 0 passed, 1 rejected
    task automatic run_round(input bit pass, input bit good_kind, input bit chain,
                             output bit rejected);
        logic c;
        rejected = 1'b0;
        while (!commit_ready) @(negedge clk);
        if (!commit_valid) begin
            repeat ($urandom_range(0, 2)) begin
                resp_valid = 1'b1; check_done = 1'b1;
                @(negedge clk);
                resp_valid = 1'b0; check_done = 1'b0;
                chk(commit_ready == 1'b1 && reject == 1'b0, "R9 stray inputs", commit_ready, 1);
            end
        end
        commit_valid = 1'b1;
        @(negedge clk);
        commit_valid = 1'b0;
        chk(chal_valid == 1'b1, "R3 chal_valid", chal_valid, 1);
        c = chal_bit;
        if (c) seen1++; else seen0++;
        @(negedge clk);
        chk(chal_valid == 1'b0 && resp_ready == 1'b1, "R3 single strobe", chal_valid, 0);
        repeat ($urandom_range(0, 3)) begin
            check_done = 1'b1;
            @(negedge clk);
            check_done = 1'b0;
            chk(resp_ready == 1'b1, "R9 check_done ignored", resp_ready, 1);
        end
        resp_valid = 1'b1;
        resp_kind  = good_kind ? c : ~c;
        @(negedge clk);
        resp_valid = 1'b0;
        if (!good_kind) begin
            chk(reject == 1'b1, "R5 wrong reveal", reject, 1);
            rejected = 1'b1;
            return;
        end
        chk(check_req == 1'b1 && check_kind == c, "R6 check_kind", check_kind, c);
        repeat ($urandom_range(0, 3)) @(negedge clk);
        chk(check_req == 1'b1 && chal_bit == c, "R3 coin stable", chal_bit, c);
        check_done   = 1'b1;
        check_pass   = pass;
        commit_valid = chain;
        @(negedge clk);
        check_done = 1'b0;
        if (!pass) begin
            chk(reject == 1'b1, "R6 failed check", reject, 1);
            rejected = 1'b1;
            return;
        end
        chk(reject == 1'b0 && commit_ready == 1'b0, "R10 no commit in NEXT", commit_ready, 0);
    endtask

    // session; fail_at/wrong_at = round index to break (>= ROUNDS means none)
    task automatic run_session(input int fail_at, input int wrong_at, input bit chain);
        bit rej;
        for (int i = 0; i < ROUNDS; i++) begin
            run_round(i != fail_at, i != wrong_at, chain && (i != ROUNDS - 1), rej);
            if (rej) begin
                chk(accept == 1'b0, "R8 no accept after reject", accept, 0);
                return;
            end
            @(negedge clk);
            chk(rounds_passed == CW'(i + 1), "R7 rounds_passed", rounds_passed, i + 1);
            chk(accept == exp_accept(i + 1), "R7 accept timing", accept, exp_accept(i + 1));
        end
        commit_valid = 1'b0;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1234_5678);
        do_reset();
        // R1
        chk(!commit_ready && !chal_valid && !resp_ready && !check_req && !accept && !reject,
            "R1 idle outputs", {commit_ready, resp_ready, check_req, accept, reject}, 0);
        chk(rounds_passed == 0, "R1 rounds_passed", rounds_passed, 0);
        // R9: commit in IDLE ignored
        commit_valid = 1'b1;
        repeat (2) @(negedge clk);
        commit_valid = 1'b0;
        chk(commit_ready == 1'b0 && chal_valid == 1'b0, "R9 commit in IDLE", chal_valid, 0);

        begin_session();
        run_session(ROUNDS, ROUNDS, 1'b0);
        chk(accept == 1'b1, "R7 accepted", accept, 1);
        // R2 restart from ACCEPT, chained commits (R10)
        begin_session();
        run_session(ROUNDS, ROUNDS, 1'b1);
        chk(accept == 1'b1, "R10 chained session accepted", accept, 1);

        begin_session();
        run_session(2, ROUNDS, 1'b0);
        // R8 sticky
        start = 1'b1; commit_valid = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0; commit_valid = 1'b0;
        chk(reject == 1'b1 && commit_ready == 1'b0, "R8 reject sticky", reject, 1);

        do_reset();
        begin_session();
        run_session(ROUNDS, 0, 1'b0);
        chk(reject == 1'b1, "R5 reject on round 0", reject, 1);

        for (int s = 0; s < 12; s++) begin
            int f, w;
            do_reset();
            begin_session();
            f = ($urandom_range(0, 2) == 0) ? $urandom_range(0, ROUNDS - 1) : ROUNDS;
            w = ($urandom_range(0, 3) == 0) ? $urandom_range(0, ROUNDS - 1) : ROUNDS;
            run_session(f, w, $urandom_range(0, 1));
            chk(accept == (f == ROUNDS && w == ROUNDS), "R7 random session accept",
                accept, (f == ROUNDS && w == ROUNDS));
            chk(reject == (f != ROUNDS || w != ROUNDS), "R8 random session reject",
                reject, (f != ROUNDS || w != ROUNDS));
        end
        chk(seen0 > 0 && seen1 > 0, "R4 both coins", seen0 * 1000 + seen1, 1);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule